// File: doc/BRIEF.md
# Presence-Tagged Synchronizing Word Memory

This block is a word-addressed store in which each 32-bit data word carries one presence bit that says whether the word is full or empty. A producer and a consumer can coordinate through individual words. In one access, a single operation can test the presence bit, refuse with a trap, move the data and update the bit. No other agent can slip in between these steps.

Requests enter through one valid/ready port. Each request carries a word address, write data and a 3-bit operation code. The block performs the read-modify-write in the accepting cycle. It answers one cycle later with the word's data, its presence bit and a trap flag. Presence bits are kept in a separate array, four words to a line, away from the data storage. Each response also returns the whole 4-bit presence vector of the addressed line.

Top module: `fe_sync_mem`

## Requirements
- R1: After reset every presence bit is empty (0) and every data word is zero. rsp_valid_o is low until the first accepted request. req_ready_o is high from the first clock edge after reset release.
- R2: A request is accepted on a rising edge where req_valid_i and req_ready_o are both high. rsp_valid_o is high in exactly the cycle after each acceptance and low otherwise.
- R3: Operation codes: 0 plain load, 1 plain store, 2 trapping load, 3 consuming load, 4 fill store, 5 trapping store. Codes 6 and 7 behave as a plain load.
- R4: A plain load returns the word and never traps. Data and presence bit are left as they were.
- R5: A plain store writes the data and leaves the presence bit unchanged. It never traps.
- R6: A trapping load returns the data and raises rsp_trap_o when the word is empty. It never changes data or presence.
- R7: A consuming load on an empty word raises rsp_trap_o. On a full word it returns the data without trap and marks the word empty.
- R8: A fill store writes the data and marks the word full whatever its previous state. It never traps.
- R9: A trapping store on a full word raises rsp_trap_o and leaves the word unchanged. On an empty word it writes the data and marks the word full.
- R10: Any trapped operation leaves both data and presence storage unmodified.
- R11: rsp_rdata_o and rsp_full_o give the word's data and presence bit as they were before the operation.
- R12: rsp_line_pres_o gives the addressed line's four presence bits after the operation. Bit k belongs to the word whose address ends in k (address bits [1:0]), and the line is address bits [5:2].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block can accept a request |
| req_addr_i | input | 6 | Word address |
| req_op_i | input | 3 | Operation code |
| req_wdata_i | input | 32 | Store data |
| rsp_valid_o | output | 1 | Response present |
| rsp_rdata_o | output | 32 | Word data before the operation |
| rsp_full_o | output | 1 | Presence bit before the operation |
| rsp_trap_o | output | 1 | Operation refused |
| rsp_line_pres_o | output | 4 | Line presence vector after the operation |

## Verification
The assertions watch, on every cycle, properties that hold for any traffic:
- A response follows each acceptance by exactly one cycle.
- A trap never coexists with a write enable.
- Both storage arrays hold still whenever no write is enabled.
- A successful consuming load or fill store leaves the right presence bit in the next response.

Only the bench's scenarios can show that data written earlier comes back intact and that reserved codes have no effect. The same holds for the full interplay of empty and full words under long mixed sequences, which the bench compares against its own reference model.

// File: rtl/fe_mem_pkg.sv
package fe_mem_pkg;
  localparam int unsigned OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_LOAD      = 3'd0,
    OP_STORE     = 3'd1,
    OP_LOAD_TRAP = 3'd2,
    OP_LOAD_TAKE = 3'd3,
    OP_STORE_SET = 3'd4,
    OP_STORE_TRAP= 3'd5,
    OP_RSVD6     = 3'd6,
    OP_RSVD7     = 3'd7
  } fe_op_e;

  typedef struct packed {
    logic trap;
    logic data_we;
    logic pres_we;
    logic pres_new;
  } fe_action_t;
endpackage

// File: rtl/fe_op_decode.sv
module fe_op_decode
  import fe_mem_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  input  logic            full_i,
  output fe_action_t      act_o
);
  always_comb begin
    act_o = '0;
    unique case (fe_op_e'(op_i))
      OP_STORE: act_o.data_we = 1'b1;
      OP_LOAD_TRAP: act_o.trap = ~full_i;
      OP_LOAD_TAKE: begin
        act_o.trap     = ~full_i;
        act_o.pres_we  = full_i;
        act_o.pres_new = 1'b0;
      end
      OP_STORE_SET: begin
        act_o.data_we  = 1'b1;
        act_o.pres_we  = 1'b1;
        act_o.pres_new = 1'b1;
      end
      OP_STORE_TRAP: begin
        act_o.trap     = full_i;
        act_o.data_we  = ~full_i;
        act_o.pres_we  = ~full_i;
        act_o.pres_new = 1'b1;
      end
      default: act_o = '0; // load and reserved codes
    endcase
  end

  // trapped ops must not enable any write (R10)
  always_comb begin
    a_trap_no_write_r10: assert (!(act_o.trap && (act_o.data_we || act_o.pres_we)));
  end
endmodule

// File: rtl/fe_pres_array.sv
module fe_pres_array #(
  parameter int unsigned LINES = 16,
  parameter int unsigned WPL   = 4,
  localparam int unsigned LW   = (LINES > 1) ? $clog2(LINES) : 1,
  localparam int unsigned SW   = (WPL > 1) ? $clog2(WPL) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [LW-1:0]  line_i,
  output logic [WPL-1:0] line_vec_o,
  input  logic           we_i,
  input  logic [SW-1:0]  sel_i,
  input  logic           val_i
);
  logic [LINES-1:0][WPL-1:0] pres_q;

  assign line_vec_o = pres_q[line_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pres_q <= '0;
    else if (we_i) pres_q[line_i][sel_i] <= val_i;
  end

  p_pres_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> pres_q == $past(pres_q));
endmodule

// File: rtl/fe_word_array.sv
module fe_word_array #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned DW    = 32,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  output logic [DW-1:0] rdata_o,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i
);
  logic [DEPTH-1:0][DW-1:0] mem_q;

  assign rdata_o = mem_q[addr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mem_q <= '0;
    else if (we_i) mem_q[addr_i] <= wdata_i;
  end

  p_data_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> mem_q == $past(mem_q));
endmodule

// File: rtl/fe_sync_mem.sv
module fe_sync_mem
  import fe_mem_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned AW    = 6,
  parameter int unsigned SEL_W = 2,
  localparam int unsigned WPL   = 1 << SEL_W,
  localparam int unsigned DEPTH = 1 << AW,
  localparam int unsigned LINES = DEPTH / WPL,
  localparam int unsigned LW    = AW - SEL_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic [AW-1:0]   req_addr_i,
  input  logic [OP_W-1:0] req_op_i,
  input  logic [DW-1:0]   req_wdata_i,
  output logic            rsp_valid_o,
  output logic [DW-1:0]   rsp_rdata_o,
  output logic            rsp_full_o,
  output logic            rsp_trap_o,
  output logic [WPL-1:0]  rsp_line_pres_o
);
  logic             ready_q, accept;
  logic [LW-1:0]    line;
  logic [SEL_W-1:0] sel;
  logic [WPL-1:0]   line_vec, line_vec_nxt;
  logic [DW-1:0]    cur_data;
  logic             cur_full;
  fe_action_t       act;

  assign line   = req_addr_i[AW-1:SEL_W];
  assign sel    = req_addr_i[SEL_W-1:0];
  assign accept = req_valid_i & ready_q;
  assign req_ready_o = ready_q;
  assign cur_full = line_vec[sel];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ready_q <= 1'b0;
    else         ready_q <= 1'b1;
  end

  fe_op_decode u_dec (
    .op_i   (req_op_i),
    .full_i (cur_full),
    .act_o  (act)
  );

  fe_pres_array #(.LINES(LINES), .WPL(WPL)) u_pres (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .line_i     (line),
    .line_vec_o (line_vec),
    .we_i       (accept & act.pres_we),
    .sel_i      (sel),
    .val_i      (act.pres_new)
  );

  fe_word_array #(.DEPTH(DEPTH), .DW(DW)) u_data (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (req_addr_i),
    .rdata_o (cur_data),
    .we_i    (accept & act.data_we),
    .wdata_i (req_wdata_i)
  );

  always_comb begin
    line_vec_nxt = line_vec;
    if (act.pres_we) line_vec_nxt[sel] = act.pres_new;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o     <= 1'b0;
      rsp_rdata_o     <= '0;
      rsp_full_o      <= 1'b0;
      rsp_trap_o      <= 1'b0;
      rsp_line_pres_o <= '0;
    end else begin
      rsp_valid_o <= accept;
      if (accept) begin
        rsp_rdata_o     <= cur_data;
        rsp_full_o      <= cur_full;
        rsp_trap_o      <= act.trap;
        rsp_line_pres_o <= line_vec_nxt;
      end
    end
  end

  p_rsp_follows_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> rsp_valid_o);
  p_no_rsp_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept |=> !rsp_valid_o);
  p_take_empties_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && req_op_i == OP_LOAD_TAKE && cur_full)
      |=> !rsp_trap_o && !rsp_line_pres_o[$past(sel)]);
  p_set_fills_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && req_op_i == OP_STORE_SET)
      |=> !rsp_trap_o && rsp_line_pres_o[$past(sel)]);
  p_trap_store_full_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && req_op_i == OP_STORE_TRAP && cur_full) |=> rsp_trap_o);
endmodule

// File: tb/fe_sync_mem_bench.sv
`timescale 1ns/1ps
module fe_sync_mem_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [5:0]  req_addr = '0;
  logic [2:0]  req_op = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_full, rsp_trap;
  logic [31:0] rsp_rdata;
  logic [3:0]  rsp_line;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] m_data [64];
  logic        m_pres [64];

  always #2 clk = ~clk;

  fe_sync_mem u_fe_sync_mem (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_op_i(req_op), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .rsp_full_o(rsp_full),
    .rsp_trap_o(rsp_trap), .rsp_line_pres_o(rsp_line)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit f_trap(input logic [2:0] op, input bit full);
    case (op)
      3'd2, 3'd3: return !full;
      3'd5:       return full;
      default:    return 1'b0;
    endcase
  endfunction

  function automatic bit f_wr(input logic [2:0] op, input bit full);
    return (op == 3'd1) || (op == 3'd4) || (op == 3'd5 && !full);
  endfunction

  function automatic bit f_next_pres(input logic [2:0] op, input bit full);
    case (op)
      3'd3:       return full ? 1'b0 : full;
      3'd4:       return 1'b1;
      3'd5:       return 1'b1;
      default:    return full;
    endcase
  endfunction

  function automatic string f_req(input logic [2:0] op);
    case (op)
      3'd0: return "R4";
      3'd1: return "R5";
      3'd2: return "R6";
      3'd3: return "R7";
      3'd4: return "R8";
      3'd5: return "R9";
      default: return "R3";
    endcase
  endfunction

  // entered and left at a falling edge
  task automatic do_req(input logic [2:0] op, input logic [5:0] addr, input logic [31:0] wd);
    bit full, trap;
    logic [31:0] old;
    logic [3:0] vec;
    string rq;
    full = m_pres[addr];
    old  = m_data[addr];
    trap = f_trap(op, full);
    rq   = f_req(op);
    if (f_wr(op, full)) m_data[addr] = wd;
    m_pres[addr] = f_next_pres(op, full);
    for (int k = 0; k < 4; k++) vec[k] = m_pres[{addr[5:2], 2'(k)}];
    req_valid = 1'b1; req_op = op; req_addr = addr; req_wdata = wd;
    @(posedge clk);
    #1 req_valid = 1'b0;
    @(negedge clk);
    chk(rsp_valid == 1'b1, "R2 rsp_valid", 32'(rsp_valid), 32'd1);
    chk(rsp_trap == trap, {rq, " R10 trap"}, 32'(rsp_trap), 32'(trap));
    chk(rsp_full == full, {rq, " R11 full"}, 32'(rsp_full), 32'(full));
    chk(rsp_rdata == old, {rq, " R11 data"}, rsp_rdata, old);
    chk(rsp_line == vec, {rq, " R12 line"}, 32'(rsp_line), 32'(vec));
  endtask

  task automatic idle();
    @(posedge clk);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R2 idle", 32'(rsp_valid), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 64; i++) begin m_data[i] = '0; m_pres[i] = 1'b0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", 32'(rsp_valid), 32'd0);
    chk(req_ready == 1'b1, "R1 ready", 32'(req_ready), 32'd1);
    // R1: reset contents empty and zero
    do_req(3'd0, 6'd0, 32'h0);
    do_req(3'd0, 6'd63, 32'h0);
    idle();
    // R6 / R7 on empty, R9 on empty, then full cases
    do_req(3'd2, 6'd5, 32'h0);
    do_req(3'd3, 6'd5, 32'h0);
    do_req(3'd5, 6'd5, 32'hA5A5_0001);
    do_req(3'd5, 6'd5, 32'hDEAD_BEEF);   // R9 full: unchanged
    do_req(3'd2, 6'd5, 32'h0);
    do_req(3'd3, 6'd5, 32'h0);           // R7 empties
    do_req(3'd3, 6'd5, 32'h0);           // R7 traps now
    // R8 over full word, R5 keeps presence
    do_req(3'd4, 6'd6, 32'h1111_2222);
    do_req(3'd4, 6'd6, 32'h3333_4444);
    do_req(3'd1, 6'd6, 32'h5555_6666);
    do_req(3'd1, 6'd7, 32'h7777_8888);
    do_req(3'd0, 6'd7, 32'h0);
    // R3 reserved codes act as load
    do_req(3'd6, 6'd6, 32'hFFFF_FFFF);
    do_req(3'd7, 6'd6, 32'hFFFF_FFFF);
    do_req(3'd0, 6'd6, 32'h0);
    idle();
    // random mix on a small window to force reuse
    for (int n = 0; n < 600; n++) begin
      logic [2:0] op;
      logic [5:0] a;
      op = 3'($urandom % 8);
      a  = ($urandom % 4 == 0) ? 6'($urandom) : 6'(8 + ($urandom % 8));
      do_req(op, a, $urandom);
      if ($urandom % 8 == 0) idle();
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule